// File: doc/BRIEF.md
# Link Event Statistics Counters

This block keeps running counts of two kinds of link activity: how many times the link has been switched on, and how many times each of eight interrupt sources has fired. A source is counted on the raw line, before any interrupt masking is applied. Events that occur while the link is switched off are not counted. This keeps start-up noise out of the statistics, such as glitches from an unstable link clock.

Software reads the counts through a simple word-addressed register port. Two 16-bit interrupt counters are packed into each 32-bit word. A single write to a control word zeroes every counter at once. Counters stop at their largest value instead of wrapping, so a full counter shows that the count overflowed rather than giving a small, misleading number. Read data is registered and appears one clock after the address is presented.

Top module: `link_evt_stats`

## Requirements
- R1: After reset every counter is zero, and every mapped word reads as zero.
- R2: Each rising edge of `link_en` adds one to the link-enable counter. This counter is read at word 0x0B1 in bits [15:0], and bits [31:16] of that word read as zero.
- R3: Every counter holds at its largest value (2^CNT_W-1, which is 0xFFFF by default) and never wraps. Further events leave it unchanged.
- R4: A rising edge on `irq_src[i]` while `link_en` is high adds one to counter i. Counter i is read at word 0x0B4 + i/2. An even i sits in bits [15:0] and an odd i in bits [31:16]. Edges on several sources in the same cycle are all counted.
- R5: Interrupt edges that occur while `link_en` is low are not counted. This includes a source that rose while the link was low and is still high when the link comes up.
- R6: An interrupt source held high for many cycles counts once. Only its rising edge is counted.
- R7: A write to word 0x0B0 with bit 0 set clears every counter on that clock edge. If an event arrives on the same edge, the clear wins. Counting resumes from zero afterwards.
- R8: A write to word 0x0B0 with bit 0 clear, or a write to any other address, leaves every counter unchanged.
- R9: A read of any address other than 0x0B1 and 0x0B4 to 0x0B7 returns zero. This includes the control word 0x0B0.
- R10: `reg_rdata` is registered. It shows the counter values as they stood just before the clock edge that samples `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_en | input | 1 | Link enable level |
| irq_src | input | NUM_SRC | Raw, unmasked interrupt source lines |
| reg_addr | input | ADDR_W | Word address for reads and writes |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data for `reg_addr` |

## Verification
The bench builds the block with eight sources and CNT_W set to 4. With this setting each counter saturates after fifteen events, so the hold-at-maximum behaviour is reached on every counter within a few hundred cycles. The field packing is still checked at its full 16-bit positions.

The bench sweeps every source with a distinct pulse count, so any swap of fields or words shows up. It also covers simultaneous edges, held levels, edges while the link is down and a clear that coincides with events. Unmapped addresses on both sides of the map are read and must return zero.

// File: rtl/lstat_pkg.sv
package lstat_pkg;

  // Word addresses of the statistics map
  localparam int unsigned CTRL_WORD     = 32'h0B0;
  localparam int unsigned LINK_WORD     = 32'h0B1;
  localparam int unsigned IRQ_BASE_WORD = 32'h0B4;

  // Bit of the control word that clears all counters
  localparam int unsigned CLR_BIT = 0;

  // Saturating step: advance by one unless already at the limit
  function automatic logic [31:0] sat_step(input logic [31:0] cur,
                                           input logic [31:0] lim);
    return (cur >= lim) ? lim : cur + 32'd1;
  endfunction

  // Word index that holds interrupt counter idx
  function automatic int unsigned irq_word_of(input int unsigned idx);
    return IRQ_BASE_WORD + idx / 2;
  endfunction

endpackage

// File: rtl/lstat_edge.sv
module lstat_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise
);
  logic [W-1:0] sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
endmodule

// File: rtl/lstat_counter.sv
module lstat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  import lstat_pkg::*;

  localparam logic [31:0] LIMIT = 32'((64'd1 << CNT_W) - 64'd1);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= CNT_W'(sat_step(32'(cnt), LIMIT));
  end
endmodule

// File: rtl/lstat_regfile.sv
module lstat_regfile #(
  parameter int NUM_SRC = 8,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic                     reg_wr,
  input  logic [DATA_W-1:0]        reg_wdata,
  input  logic [CNT_W-1:0]         link_cnt,
  input  logic [NUM_SRC*CNT_W-1:0] irq_cnt_flat,
  output logic                     stat_clr,
  output logic [DATA_W-1:0]        reg_rdata
);
  import lstat_pkg::*;

  localparam int FIELD_W   = DATA_W / 2;
  localparam int NUM_WORDS = NUM_SRC / 2;

  logic [DATA_W-1:0] irq_word [NUM_WORDS];
  logic [DATA_W-1:0] rd_nxt;

  // Pack an even/odd pair of counters into one word
  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_pack
    assign irq_word[k] = {FIELD_W'(irq_cnt_flat[(2*k+1)*CNT_W +: CNT_W]),
                          FIELD_W'(irq_cnt_flat[(2*k)*CNT_W +: CNT_W])};
  end

  assign stat_clr = reg_wr && (reg_addr == ADDR_W'(CTRL_WORD)) && reg_wdata[CLR_BIT];

  always_comb begin
    rd_nxt = '0;
    if (reg_addr == ADDR_W'(LINK_WORD)) rd_nxt = DATA_W'(link_cnt);
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (reg_addr == ADDR_W'(IRQ_BASE_WORD + k)) rd_nxt = irq_word[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_nxt;
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;
endmodule

// File: rtl/link_evt_stats.sv
module link_evt_stats #(
  parameter int NUM_SRC = 8,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               link_en,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata
);
  // Named internal events, brought out for the checker
  logic                     link_evt;
  logic [NUM_SRC-1:0]       irq_rise;
  logic [NUM_SRC-1:0]       irq_evt;
  logic                     stat_clr;
  logic [CNT_W-1:0]         link_cnt;
  logic [NUM_SRC*CNT_W-1:0] irq_cnt_flat;

  lstat_edge #(.W(1)) u_link_edge (
    .clk(clk), .rst_n(rst_n), .sig(link_en), .rise(link_evt)
  );

  lstat_edge #(.W(NUM_SRC)) u_irq_edge (
    .clk(clk), .rst_n(rst_n), .sig(irq_src), .rise(irq_rise)
  );

  // Interrupt edges only count while the link is up
  assign irq_evt = irq_rise & {NUM_SRC{link_en}};

  lstat_counter #(.CNT_W(CNT_W)) u_link_cnt (
    .clk(clk), .rst_n(rst_n), .clr(stat_clr), .inc(link_evt), .cnt(link_cnt)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_irq_cnt
    lstat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(stat_clr), .inc(irq_evt[i]),
      .cnt(irq_cnt_flat[i*CNT_W +: CNT_W])
    );
  end

  lstat_regfile #(
    .NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .link_cnt(link_cnt), .irq_cnt_flat(irq_cnt_flat),
    .stat_clr(stat_clr), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/link_evt_stats_chk.sv
module link_evt_stats_chk #(
  parameter int NUM_SRC = 8,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     link_en,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic [DATA_W-1:0]        reg_rdata,
  input logic                     stat_clr,
  input logic                     link_evt,
  input logic [NUM_SRC-1:0]       irq_evt,
  input logic [CNT_W-1:0]         link_cnt,
  input logic [NUM_SRC*CNT_W-1:0] irq_cnt_flat
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic addr_unmapped;
  assign addr_unmapped = !((reg_addr == ADDR_W'(12'h0B1)) ||
                           ((reg_addr >= ADDR_W'(12'h0B4)) &&
                            (reg_addr <  ADDR_W'(12'h0B4 + NUM_SRC / 2))));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> (link_cnt == '0) && (irq_cnt_flat == '0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_cnt == TOP) && !stat_clr |=> link_cnt == TOP);

  p_link_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr && !link_evt |=> $stable(link_cnt));

  p_down_no_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en && !stat_clr |=> $stable(irq_cnt_flat));

  p_evt_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt != '0) |-> link_en);

  p_link_evt_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    link_evt |-> link_en);

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_unmapped |=> reg_rdata == '0);
endmodule

bind link_evt_stats link_evt_stats_chk #(
  .NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .link_en(link_en), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .stat_clr(stat_clr), .link_evt(link_evt),
  .irq_evt(irq_evt), .link_cnt(link_cnt), .irq_cnt_flat(irq_cnt_flat)
);

// File: tb/link_evt_stats_tb.sv
module link_evt_stats_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;
  localparam int CW   = 4;
  localparam int SATV = 15;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            link_en = 1'b0;
  logic [NSRC-1:0] irq_src = '0;
  logic [11:0]     reg_addr = '0;
  logic            reg_wr = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;

  int checks = 0;
  int errors = 0;
  int exp_link = 0;
  int exp_irq [NSRC];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_evt_stats #(.NUM_SRC(NSRC), .CNT_W(CW), .ADDR_W(12), .DATA_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .link_en(link_en), .irq_src(irq_src),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  function automatic int bump(input int v);
    return (v >= SATV) ? SATV : v + 1;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic read_word(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk) reg_addr = a;
    @(posedge clk);
    @(negedge clk) d = reg_rdata;
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    read_word(12'h0B1, d);
    check({req, " link word"}, d, 32'(exp_link));
    for (int k = 0; k < NSRC/2; k++) begin
      read_word(12'(12'h0B4 + k), d);
      check({req, " irq word"}, d, {16'(exp_irq[2*k+1]), 16'(exp_irq[2*k])});
    end
  endtask

  task automatic set_link(input logic v);
    @(negedge clk);
    if (v && !link_en) exp_link = bump(exp_link);
    link_en = v;
  endtask

  task automatic pulse_srcs(input logic [NSRC-1:0] m);
    @(negedge clk);
    irq_src = m;
    if (link_en) for (int i = 0; i < NSRC; i++) if (m[i]) exp_irq[i] = bump(exp_irq[i]);
    @(negedge clk) irq_src = '0;
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk) reg_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < NSRC; i++) exp_irq[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check_all("R1");

    // R9: unmapped and control reads return zero
    read_word(12'h0B0, d); check("R9 ctrl", d, 0);
    read_word(12'h0B2, d); check("R9 b2", d, 0);
    read_word(12'h0B3, d); check("R9 b3", d, 0);
    read_word(12'h0B8, d); check("R9 b8", d, 0);
    read_word(12'h0AF, d); check("R9 af", d, 0);
    read_word(12'h000, d); check("R9 zero", d, 0);

    // R2: link-enable rising edges
    for (int n = 0; n < 3; n++) begin set_link(1'b1); set_link(1'b0); end
    set_link(1'b1);
    check_all("R2");

    // R4: sweep, source s pulsed s+1 times
    for (int s = 0; s < NSRC; s++)
      for (int n = 0; n <= s; n++) pulse_srcs(NSRC'(1) << s);
    check_all("R4 sweep");
    pulse_srcs('1);
    check_all("R4 simultaneous");

    // R6: held level counts once
    @(negedge clk) irq_src = 8'h08; exp_irq[3] = bump(exp_irq[3]);
    repeat (10) @(negedge clk);
    irq_src = '0;
    check_all("R6");

    // R5: edges while link down are ignored
    set_link(1'b0);
    pulse_srcs('1); pulse_srcs(8'h55);
    check_all("R5 down");
    @(negedge clk) irq_src = 8'h20;
    set_link(1'b1);
    @(negedge clk) irq_src = '0;
    check_all("R5 held across link up");

    // R10: read data lags the counter by one edge
    read_word(12'h0B1, d);
    set_link(1'b0);
    @(negedge clk) link_en = 1'b1;
    @(negedge clk) check("R10 old value", reg_rdata, 32'(exp_link));
    exp_link = bump(exp_link);
    @(negedge clk) check("R10 new value", reg_rdata, 32'(exp_link));

    // R3: saturation
    for (int n = 0; n < 20; n++) pulse_srcs(8'h81);
    for (int n = 0; n < 20; n++) begin set_link(1'b0); set_link(1'b1); end
    check_all("R3");

    // R8: writes that must not clear
    do_write(12'h0B0, 32'hFFFF_FFFE);
    do_write(12'h0B1, 32'h1);
    do_write(12'h0B4, 32'hFFFF_FFFF);
    check_all("R8");

    // R7: clear wins over coincident events
    set_link(1'b0);
    @(negedge clk);
    reg_addr = 12'h0B0; reg_wdata = 32'h1; reg_wr = 1'b1;
    link_en = 1'b1; irq_src = '1;
    @(negedge clk);
    reg_wr = 1'b0; irq_src = '0;
    exp_link = 0;
    for (int i = 0; i < NSRC; i++) exp_irq[i] = 0;
    check_all("R7 clear");
    pulse_srcs(8'h04);
    check_all("R7 resume");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule